// File: doc/BRIEF.md
# Serial ADC Readout Master

This block runs the host side of a three-wire link to a micropower 12-bit sampling converter. A one-cycle start request or a periodic sample tick opens a frame: chip-select goes low, and a data clock made by dividing the system clock starts. The master lets the converter take its sample and drive its leading zero bit. It then shifts in the result, most significant bit first. When the word is complete it raises chip-select again at once, which puts the converter back into shutdown.

The converter changes its data line on the falling edge of the data clock, so the master samples it on the rising edge. After the last result bit the converter sends the same word again, least significant bit first. In check mode the master keeps the clock running through that echo. It compares bits B1 to B11 with the word it has captured and reports any difference on a mismatch flag.

The result leaves the block as a one-cycle strobe with no back-pressure. The consumer must take data and the mismatch flag in the strobe cycle, or read them later: both hold until the next frame ends. Start and tick requests that arrive while a frame is in progress are dropped.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, chip-select is high, the data clock is low, and valid and busy are both low.
- R2: When the block is idle, a start or tick pulse drives chip-select low and busy high on the next clock edge.
- R3: The first rising edge of the data clock comes HALF_DIV system cycles after chip-select falls.
- R4: While chip-select is low, the data clock toggles every HALF_DIV system cycles. While chip-select is high, the data clock stays low.
- R5: Rising edges are numbered from 1 after chip-select falls. The line values sampled at edges 4 through 15 form data_o, edge 4 giving bit 11. The values at edges 1 to 3 have no effect on data_o: edges 1 and 2 fall before the converter drives the line, and edge 3 carries the zero bit.
- R6: In normal mode a frame has exactly 15 rising edges. Chip-select returns high on the falling edge that follows the 15th rising edge. valid_o is high for that one cycle only, and busy is low in that cycle.
- R7: When check mode is sampled high at the start of a frame, the frame has 26 rising edges. At edge 15+n the master compares the line with data bit n, for n = 1 to 11. mismatch_o is high with valid_o exactly when at least one of these comparisons differs. In normal mode mismatch_o is low.
- R8: A start or tick pulse while busy is high is ignored. Once the current frame has ended, chip-select stays high and no further frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to start a frame |
| tick_i | input | 1 | Periodic sample tick; acts like start_i |
| check_en_i | input | 1 | Selects check mode; sampled when a frame starts |
| adc_cs_n_o | output | 1 | Converter chip-select, active low; high means shutdown |
| adc_sclk_o | output | 1 | Data clock to the converter |
| adc_miso_i | input | 1 | Serial data from the converter |
| data_o | output | DATA_W | Last captured result, straight binary |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | High while a frame is in progress |
| mismatch_o | output | 1 | Echo check failed; qualified by valid_o |

## Verification
The assertions assume that start_i and tick_i are synchronous to clk. They also assume that HALF_DIV is at least 2, so the converter always has a full half-period between the falling clock edge and the next sample. The bench model of the converter changes its data line only on the system-clock edge after it sees the data clock fall. Before the converter would drive the line, the model holds it at one, so those early samples cannot pass for zeros. The bench raises start and tick pulses only between system clock edges, and mixes in requests during frames to cover R8.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} seq_st_t;

  // Number of rising data-clock edges in a frame
  function automatic int frame_rises(int data_w, bit chk);
    return chk ? (2 * data_w + 2) : (data_w + 3);
  endfunction
endpackage

// File: rtl/adc_rd_divider.sv
module adc_rd_divider #(
  parameter int HALF_DIV = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tc
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tc = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (run)    cnt <= tc ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_sequencer.sv
module adc_rd_sequencer
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int K_W    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           chk_req,
  input  logic           tc,
  output logic           cs_n,
  output logic           sclk,
  output logic           busy,
  output logic           launch,
  output logic           rise_evt,
  output logic [K_W-1:0] rise_idx,
  output logic           done
);
  localparam logic [K_W-1:0] LAST_NORM = K_W'(frame_rises(DATA_W, 1'b0));
  localparam logic [K_W-1:0] LAST_CHK  = K_W'(frame_rises(DATA_W, 1'b1));

  seq_st_t        st;
  logic           chk_mode;
  logic [K_W-1:0] k;
  logic [K_W-1:0] last_k;

  assign busy     = (st != ST_IDLE);
  assign launch   = (st == ST_IDLE) && req;
  assign last_k   = chk_mode ? LAST_CHK : LAST_NORM;
  assign rise_evt = tc && !sclk;
  assign rise_idx = k + 1'b1;
  assign done     = tc && sclk && (st == ST_RUN) && (k == last_k);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      chk_mode <= 1'b0;
      k        <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch) begin
          st       <= ST_SETUP;
          cs_n     <= 1'b0;
          chk_mode <= chk_req;
          k        <= '0;
        end
        ST_SETUP: if (tc) begin
          st   <= ST_RUN;
          sclk <= 1'b1;
          k    <= rise_idx;
        end
        ST_RUN: if (tc) begin
          if (sclk) begin
            sclk <= 1'b0;
            if (k == last_k) begin
              st   <= ST_IDLE;
              cs_n <= 1'b1;
            end
          end else begin
            sclk <= 1'b1;
            k    <= rise_idx;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_W = 12,
  parameter int K_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              rise_evt,
  input  logic [K_W-1:0]    rise_idx,
  input  logic              miso,
  input  logic              done,
  output logic [DATA_W-1:0] data_o,
  output logic              mismatch_o
);
  localparam logic [K_W-1:0] D_FIRST = K_W'(4);
  localparam logic [K_W-1:0] D_LAST  = K_W'(DATA_W + 3);
  localparam logic [K_W-1:0] C_FIRST = K_W'(DATA_W + 4);
  localparam logic [K_W-1:0] C_LAST  = K_W'(2 * DATA_W + 2);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shifted;
  logic [K_W-1:0]    ofs;
  logic              err;
  logic              in_data, in_chk;

  assign in_data = (rise_idx >= D_FIRST) && (rise_idx <= D_LAST);
  assign in_chk  = (rise_idx >= C_FIRST) && (rise_idx <= C_LAST);
  assign ofs     = rise_idx - D_LAST;
  assign shifted = shreg >> ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      err        <= 1'b0;
      data_o     <= '0;
      mismatch_o <= 1'b0;
    end else begin
      if (launch) begin
        err <= 1'b0;
      end else if (rise_evt) begin
        if (in_data)
          shreg <= {shreg[DATA_W-2:0], miso};
        else if (in_chk && (miso != shifted[0]))
          err <= 1'b1;
      end
      if (done) begin
        data_o     <= shreg;
        mismatch_o <= err;
      end
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W   = 12,
  parameter int HALF_DIV = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              check_en_i,
  output logic              adc_cs_n_o,
  output logic              adc_sclk_o,
  input  logic              adc_miso_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              mismatch_o
);
  localparam int K_W = $clog2(2 * DATA_W + 3);

  logic           tc, launch, rise_evt, done;
  logic [K_W-1:0] rise_idx;

  adc_rd_divider #(.HALF_DIV(HALF_DIV)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (launch),
    .run  (busy_o),
    .tc   (tc)
  );

  adc_rd_sequencer #(.DATA_W(DATA_W), .K_W(K_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (start_i | tick_i),
    .chk_req (check_en_i),
    .tc      (tc),
    .cs_n    (adc_cs_n_o),
    .sclk    (adc_sclk_o),
    .busy    (busy_o),
    .launch  (launch),
    .rise_evt(rise_evt),
    .rise_idx(rise_idx),
    .done    (done)
  );

  adc_rd_capture #(.DATA_W(DATA_W), .K_W(K_W)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .rise_evt  (rise_evt),
    .rise_idx  (rise_idx),
    .miso      (adc_miso_i),
    .done      (done),
    .data_o    (data_o),
    .mismatch_o(mismatch_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= done;
  end
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_i,
  input logic adc_cs_n_o,
  input logic adc_sclk_o,
  input logic valid_o,
  input logic busy_o
);
  // R4
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n_o |-> !adc_sclk_o);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_i || tick_i) && !busy_o) |=> (!adc_cs_n_o && busy_o));

  // R6
  valid_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (adc_cs_n_o && !busy_o));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  busy_end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);

  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i || tick_i));
endmodule

bind adc_serial_reader adc_rd_chk i_rd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .tick_i    (tick_i),
  .adc_cs_n_o(adc_cs_n_o),
  .adc_sclk_o(adc_sclk_o),
  .valid_o   (valid_o),
  .busy_o    (busy_o)
);

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
module test_adc_serial_reader;
  localparam int W  = 12;
  localparam int HD = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, tick_i = 1'b0, check_en_i = 1'b0;
  logic         adc_miso_i = 1'b1;
  logic         adc_cs_n_o, adc_sclk_o, valid_o, busy_o, mismatch_o;
  logic [W-1:0] data_o;

  int errors = 0, checks = 0;
  int rises = 0, bad_period = 0, since = 0, fcnt = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [W-1:0] m_word = '0;
  int m_corrupt = 0;

  adc_serial_reader #(.DATA_W(W), .HALF_DIV(HD)) i_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .check_en_i(check_en_i), .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o),
    .adc_miso_i(adc_miso_i), .data_o(data_o), .valid_o(valid_o),
    .busy_o(busy_o), .mismatch_o(mismatch_o)
  );

  always #2 clk = ~clk;

  // converter model and edge monitor
  always @(negedge clk) begin
    if (prev_cs && !adc_cs_n_o) begin
      since = 1; rises = 0; fcnt = 0; bad_period = 0;
    end else if (adc_sclk_o != prev_sclk) begin
      if (since != HD) bad_period++;
      since = 1;
    end else begin
      since++;
    end
    if (!prev_sclk && adc_sclk_o) rises++;
    if (adc_cs_n_o) begin
      adc_miso_i = 1'b1;
    end else if (prev_sclk && !adc_sclk_o) begin
      fcnt++;
      if (fcnt < 2)                adc_miso_i = 1'b1;
      else if (fcnt == 2)          adc_miso_i = 1'b0;
      else if (fcnt <= W + 2)      adc_miso_i = m_word[W + 2 - fcnt];
      else if (fcnt <= 2 * W + 1)
        adc_miso_i = m_word[fcnt - (W + 2)] ^ (m_corrupt == fcnt - (W + 2));
      else                         adc_miso_i = 1'b0;
    end
    prev_sclk = adc_sclk_o;
    prev_cs   = adc_cs_n_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rises(input bit c);
    return c ? 2 * W + 2 : W + 3;
  endfunction

  function automatic bit exp_mis(input bit c, input int corrupt);
    return c && corrupt >= 1 && corrupt <= W - 1;
  endfunction

  task automatic run_frame(input logic [W-1:0] word, input bit c, input int corrupt,
                           input bit use_tick, input bit poke);
    int waited;
    m_word = word; m_corrupt = corrupt;
    @(negedge clk);
    check_en_i = c;
    if (use_tick) tick_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; start_i = 1'b0; check_en_i = ~c;
    chk(busy_o && !adc_cs_n_o, "R2 launch", {busy_o, adc_cs_n_o}, 2'b10);
    waited = 0;
    while (!valid_o && waited < 2000) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 20) start_i = 1'b1;
      else if (poke && waited == 40) tick_i = 1'b1;
      else begin start_i = 1'b0; tick_i = 1'b0; end
    end
    start_i = 1'b0; tick_i = 1'b0;
    chk(valid_o, "R6 valid seen", valid_o, 1);
    chk(data_o == word, "R5 data", data_o, word);
    chk(rises == exp_rises(c), c ? "R7 edge count" : "R6 edge count", rises, exp_rises(c));
    chk(mismatch_o == exp_mis(c, corrupt), "R7 mismatch", mismatch_o, exp_mis(c, corrupt));
    chk(adc_cs_n_o && !busy_o, "R6 cs high at valid", {adc_cs_n_o, busy_o}, 2'b10);
    chk(bad_period == 0, "R3 R4 half period", bad_period, 0);
    @(negedge clk);
    chk(!valid_o, "R6 one-cycle valid", valid_o, 0);
    if (poke) begin
      repeat (4 * HD + 4) @(negedge clk);
      chk(adc_cs_n_o && !busy_o && !adc_sclk_o, "R8 ignored request",
          {adc_cs_n_o, busy_o, adc_sclk_o}, 3'b100);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(adc_cs_n_o && !adc_sclk_o && !valid_o && !busy_o, "R1 reset",
        {adc_cs_n_o, adc_sclk_o, valid_o, busy_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n_o && !adc_sclk_o && !valid_o && !busy_o, "R1 after release",
        {adc_cs_n_o, adc_sclk_o, valid_o, busy_o}, 4'b1000);
    // directed corners
    run_frame(12'hFFF, 1'b0, 0, 1'b0, 1'b0);
    run_frame(12'h000, 1'b1, 0, 1'b0, 1'b0);
    run_frame(12'h001, 1'b0, 0, 1'b1, 1'b1);
    run_frame(12'hA5A, 1'b1, 11, 1'b0, 1'b0);
    run_frame(12'h5A5, 1'b1, 1, 1'b1, 1'b1);
    run_frame(12'h800, 1'b1, 0, 1'b0, 1'b1);
    // random frames
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] w;
      bit c;
      int cor;
      w   = W'($urandom);
      c   = 1'($urandom);
      cor = ($urandom % 3 == 0) ? 1 + int'($urandom % (W - 1)) : 0;
      run_frame(w, c, cor, 1'($urandom), ($urandom % 4) == 0);
      repeat ($urandom % 5) @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule